// File: doc/BRIEF.md
# MDIO Station Manager with Reset-Time PHY Isolation

This block is the management-bus master for a network adapter: it talks to attached Ethernet PHYs through a two-wire serial management interface that uses 32-bit preamble frames. It divides the system clock down to a management clock, shifts frames out on a tri-state data line, and captures the PHY's answer on reads. A host issues single register reads or writes through a command port and gets one response pulse back for each one.

After every hardware reset, and before the host can reach the bus, a built-in sequencer writes the isolate and power-down bits into the control register of three PHY addresses in a fixed order: address 0, then the primary PHY, then the secondary PHY. The primary and secondary addresses come from two configuration bytes. If either byte marks its PHY as not fitted, that write is skipped. A mode input decides whether host commands may take the bus. While it is low, the bus is left to hardware and host commands wait.

The command port is valid/ready. A command is taken on a clock where `cmd_valid` and `cmd_ready` are both high. The host must hold the command fields stable while `cmd_valid` is high and `cmd_ready` is low. The block applies back-pressure by keeping `cmd_ready` low in three cases: while a frame is on the wire, while the reset sequence runs, and while software ownership is off. The response side has no back-pressure: `rsp_valid` is a one-cycle pulse.

Top module: `mdio_station`

## Requirements
- R1: `mdc` is low out of reset and toggles every `HALF_CYCLES` clock cycles, so each high and low phase lasts exactly `HALF_CYCLES` cycles.
- R2: `mdio_o` and `mdio_oe` change only on the clock edge where `mdc` falls. `mdio_i` is sampled on the edge where `mdc` rises.
- R3: Every frame is 64 bit times, sent MSB first: 32 ones, start `01`, opcode (`10` read, `01` write), 5-bit PHY address, 5-bit register address, a 2-bit turnaround (driven `10` on writes), then 16 data bits.
- R4: On a read, `mdio_oe` is low from the first turnaround bit through the last data bit. `rsp_rdata` returns the 16 bits seen at the rising `mdc` edges of the data bit times, MSB first, and holds them until the next read completes.
- R5: After each reset the block writes 16'h0C00 (bit 11 power-down, bit 10 isolate) to register 0 of PHY address 0, then of the primary address, then of the secondary address, one frame each, in that order.
- R6: Each configuration byte is laid out as {type[7:5], address[4:0]}. A type of 3'b111 removes that PHY's write from the sequence. Any other type leaves it in.
- R7: While the reset sequence runs, `busy` is high and `cmd_ready` is low. Sequence frames raise no `rsp_valid`.
- R8: An accepted command puts exactly one frame with its address, register and data on the wire. `cmd_ready` stays low until that frame ends, and `rsp_valid` then pulses for one cycle.
- R9: With `sw_mode` low, `cmd_ready` stays low and no frame starts, even with `cmd_valid` held high. Raising `sw_mode` lets the held command proceed.
- R10: Between frames `mdio_oe` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low hardware reset; starts the isolation sequence |
| sw_mode | input | 1 | 1: host commands own the bus; 0: hardware only |
| cfg_primary | input | 8 | {type[2:0], address[4:0]} of the primary PHY |
| cfg_secondary | input | 8 | {type[2:0], address[4:0]} of the secondary PHY |
| cmd_valid | input | 1 | Host command valid |
| cmd_ready | output | 1 | Block can accept a command |
| cmd_write | input | 1 | 1: register write, 0: register read |
| cmd_phy | input | 5 | Target PHY address |
| cmd_reg | input | 5 | Target register address |
| cmd_wdata | input | 16 | Write data |
| rsp_valid | output | 1 | One-cycle pulse when a host frame completes |
| rsp_rdata | output | 16 | Data of the last completed read |
| busy | output | 1 | Sequence running or frame in progress |
| mdc | output | 1 | Management clock |
| mdio_o | output | 1 | Management data out |
| mdio_oe | output | 1 | Output enable for the management data pad |
| mdio_i | input | 1 | Management data in from the pad |

## Verification
A bit counter that is off by one inside the frame engine shows up as a preamble that is not exactly 32 ones, or as a misplaced turnaround. The PHY model sees this at the first frame after reset, well before any host traffic. A wrong sequencer state produces a missing, repeated or reordered isolation write, or a `busy` that falls early. This is visible within the first three frames. A wrong sampling phase in the read path shifts `rsp_rdata` by one bit, and it appears on the first read of a value that is not uniform.

// File: rtl/mdio_pkg.sv
package mdio_pkg;
  localparam int PHY_AW     = 5;
  localparam int REG_AW     = 5;
  localparam int DATA_W     = 16;
  localparam int PRE_BITS   = 32;
  localparam int FRAME_BITS = PRE_BITS + 2 + 2 + PHY_AW + REG_AW + 2 + DATA_W;
  localparam int TA_POS     = FRAME_BITS - DATA_W - 2;
  localparam int DATA_POS   = FRAME_BITS - DATA_W;
  localparam int NUM_TARGETS = 3;
  localparam logic [2:0] PHY_TYPE_ABSENT = 3'b111;
  localparam logic [DATA_W-1:0] ISO_WORD = 16'h0C00;

  typedef struct packed {
    logic              write;
    logic [PHY_AW-1:0] phy;
    logic [REG_AW-1:0] regad;
    logic [DATA_W-1:0] wdata;
  } mdio_req_t;

  typedef enum logic [1:0] {S_PICK, S_ISSUE, S_WAIT, S_DONE} seq_state_e;

  function automatic logic [FRAME_BITS-1:0] build_frame(input mdio_req_t r);
    logic [1:0] op;
    logic [1:0] ta;
    logic [DATA_W-1:0] d;
    op = r.write ? 2'b01 : 2'b10;
    ta = r.write ? 2'b10 : 2'b11;
    d  = r.write ? r.wdata : '1;
    return {{PRE_BITS{1'b1}}, 2'b01, op, r.phy, r.regad, ta, d};
  endfunction
endpackage

// File: rtl/mdc_gen.sv
module mdc_gen #(
  parameter int HALF_CYCLES = 32
) (
  input  logic clk,
  input  logic rst_n,
  output logic mdc,
  output logic tick_rise,
  output logic tick_fall
);
  localparam int CW = (HALF_CYCLES > 2) ? $clog2(HALF_CYCLES) : 1;
  localparam logic [CW-1:0] LAST = CW'(HALF_CYCLES - 1);

  logic [CW-1:0] cnt_q;
  logic          mdc_q;
  logic          wrap;

  assign wrap      = (cnt_q == LAST);
  assign tick_rise = wrap & ~mdc_q;
  assign tick_fall = wrap & mdc_q;
  assign mdc       = mdc_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      mdc_q <= 1'b0;
    end else if (wrap) begin
      cnt_q <= '0;
      mdc_q <= ~mdc_q;
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  assert_mdc_half_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(mdc_q) |-> ($past(cnt_q) == LAST));
endmodule

// File: rtl/mdio_engine.sv
module mdio_engine
  import mdio_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              mdc,
  input  logic              tick_rise,
  input  logic              tick_fall,
  input  logic              start,
  input  mdio_req_t         req,
  input  logic              mdio_i,
  output logic              active,
  output logic              done,
  output logic [DATA_W-1:0] rdata,
  output logic              mdio_o,
  output logic              mdio_oe
);
  localparam int IW = $clog2(FRAME_BITS + 1);
  localparam logic [IW-1:0] LAST_IDX = IW'(FRAME_BITS);
  localparam logic [IW-1:0] TA_IDX   = IW'(TA_POS);
  localparam logic [IW-1:0] DAT_IDX  = IW'(DATA_POS);

  logic [FRAME_BITS-1:0] sh_q;
  logic [IW-1:0]         idx_q;
  logic                  wr_q, act_q, done_q, o_q, oe_q;
  logic [DATA_W-1:0]     rx_q, rdata_q;

  assign active  = act_q;
  assign done    = done_q;
  assign rdata   = rdata_q;
  assign mdio_o  = o_q;
  assign mdio_oe = oe_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q    <= '0;
      idx_q   <= '0;
      wr_q    <= 1'b0;
      act_q   <= 1'b0;
      done_q  <= 1'b0;
      o_q     <= 1'b1;
      oe_q    <= 1'b0;
      rx_q    <= '0;
      rdata_q <= '0;
    end else begin
      done_q <= 1'b0;
      if (!act_q) begin
        if (start) begin
          sh_q  <= build_frame(req);
          wr_q  <= req.write;
          idx_q <= '0;
          act_q <= 1'b1;
          rx_q  <= '0;
        end
      end else begin
        if (tick_fall) begin
          if (idx_q == LAST_IDX) begin
            act_q  <= 1'b0;
            oe_q   <= 1'b0;
            done_q <= 1'b1;
            if (!wr_q) rdata_q <= rx_q;
          end else begin
            o_q   <= sh_q[FRAME_BITS-1];
            sh_q  <= {sh_q[FRAME_BITS-2:0], 1'b0};
            oe_q  <= wr_q | (idx_q < TA_IDX);
            idx_q <= idx_q + 1'b1;
          end
        end
        if (tick_rise && !wr_q && (idx_q > DAT_IDX))
          rx_q <= {rx_q[DATA_W-2:0], mdio_i};
      end
    end
  end

  assert_out_on_fall_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(o_q) |-> $fell(mdc));
  assert_oe_on_fall_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(oe_q) |-> $fell(mdc));
  assert_ta_release_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (act_q && !wr_q && (idx_q > TA_IDX)) |-> !oe_q);
  assert_done_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |=> !done_q);
  assert_idle_release_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !act_q |-> !oe_q);
endmodule

// File: rtl/isolate_seq.sv
module isolate_seq
  import mdio_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic [7:0] cfg_primary,
  input  logic [7:0] cfg_secondary,
  input  logic      eng_idle,
  input  logic      eng_done,
  output logic      start,
  output mdio_req_t req,
  output logic      seq_done
);
  localparam int SW = $clog2(NUM_TARGETS + 1);
  localparam logic [SW-1:0] END_STEP = SW'(NUM_TARGETS);

  seq_state_e  st_q;
  logic [SW-1:0] step_q;
  logic [PHY_AW-1:0] tgt_addr [NUM_TARGETS];
  logic              tgt_skip [NUM_TARGETS];
  logic [PHY_AW-1:0] cur_addr;
  logic              cur_skip;

  // target 0 is the broadcast-style address 0, then primary, then secondary
  genvar g;
  generate
    for (g = 0; g < NUM_TARGETS; g++) begin : g_tgt
      if (g == 0) begin : g_zero
        assign tgt_addr[g] = '0;
        assign tgt_skip[g] = 1'b0;
      end else if (g == 1) begin : g_pri
        assign tgt_addr[g] = cfg_primary[PHY_AW-1:0];
        assign tgt_skip[g] = (cfg_primary[7:5] == PHY_TYPE_ABSENT);
      end else begin : g_sec
        assign tgt_addr[g] = cfg_secondary[PHY_AW-1:0];
        assign tgt_skip[g] = (cfg_secondary[7:5] == PHY_TYPE_ABSENT);
      end
    end
  endgenerate

  always_comb begin
    cur_addr = '0;
    cur_skip = 1'b0;
    for (int i = 0; i < NUM_TARGETS; i++) begin
      if (step_q == SW'(i)) begin
        cur_addr = tgt_addr[i];
        cur_skip = tgt_skip[i];
      end
    end
  end

  assign req.write = 1'b1;
  assign req.phy   = cur_addr;
  assign req.regad = '0;
  assign req.wdata = ISO_WORD;
  assign start     = (st_q == S_ISSUE) && eng_idle;
  assign seq_done  = (st_q == S_DONE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= S_PICK;
      step_q <= '0;
    end else begin
      unique case (st_q)
        S_PICK: begin
          if (step_q == END_STEP) st_q <= S_DONE;
          else if (cur_skip)      step_q <= step_q + 1'b1;
          else                    st_q <= S_ISSUE;
        end
        S_ISSUE: if (eng_idle) st_q <= S_WAIT;
        S_WAIT: begin
          if (eng_done) begin
            step_q <= step_q + 1'b1;
            st_q   <= S_PICK;
          end
        end
        default: st_q <= S_DONE;
      endcase
    end
  end

  assert_order_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == S_WAIT && eng_done) |=> (step_q == $past(step_q) + 1'b1));
endmodule

// File: rtl/mdio_station.sv
module mdio_station
  import mdio_pkg::*;
#(
  parameter int HALF_CYCLES = 32
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        sw_mode,
  input  logic [7:0]  cfg_primary,
  input  logic [7:0]  cfg_secondary,
  input  logic        cmd_valid,
  output logic        cmd_ready,
  input  logic        cmd_write,
  input  logic [4:0]  cmd_phy,
  input  logic [4:0]  cmd_reg,
  input  logic [15:0] cmd_wdata,
  output logic        rsp_valid,
  output logic [15:0] rsp_rdata,
  output logic        busy,
  output logic        mdc,
  output logic        mdio_o,
  output logic        mdio_oe,
  input  logic        mdio_i
);
  logic      tick_rise, tick_fall;
  logic      eng_active, eng_done, eng_start;
  logic      seq_start, seq_done, host_fire;
  mdio_req_t seq_req, host_req, eng_req;
  logic [DATA_W-1:0] eng_rdata;

  mdc_gen #(.HALF_CYCLES(HALF_CYCLES)) u_mdc (
    .clk(clk), .rst_n(rst_n), .mdc(mdc),
    .tick_rise(tick_rise), .tick_fall(tick_fall)
  );

  isolate_seq u_seq (
    .clk(clk), .rst_n(rst_n),
    .cfg_primary(cfg_primary), .cfg_secondary(cfg_secondary),
    .eng_idle(!eng_active), .eng_done(eng_done),
    .start(seq_start), .req(seq_req), .seq_done(seq_done)
  );

  assign host_req.write = cmd_write;
  assign host_req.phy   = cmd_phy;
  assign host_req.regad = cmd_reg;
  assign host_req.wdata = cmd_wdata;

  assign cmd_ready = seq_done && sw_mode && !eng_active;
  assign host_fire = cmd_valid && cmd_ready;
  assign eng_start = seq_done ? host_fire : seq_start;
  assign eng_req   = seq_done ? host_req : seq_req;

  mdio_engine u_eng (
    .clk(clk), .rst_n(rst_n), .mdc(mdc),
    .tick_rise(tick_rise), .tick_fall(tick_fall),
    .start(eng_start), .req(eng_req), .mdio_i(mdio_i),
    .active(eng_active), .done(eng_done), .rdata(eng_rdata),
    .mdio_o(mdio_o), .mdio_oe(mdio_oe)
  );

  assign rsp_valid = eng_done && seq_done;
  assign rsp_rdata = eng_rdata;
  assign busy      = !seq_done || eng_active;

  assert_seq_iso_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (eng_start && !seq_done) |-> (eng_req.write && eng_req.regad == '0 && eng_req.wdata == ISO_WORD));
  assert_no_host_during_seq_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !seq_done |-> !rsp_valid);
  assert_mode_gate_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (eng_start && seq_done) |-> sw_mode);
endmodule

// File: tb/mdio_station_tb_top.sv
`timescale 1ns/1ps
module mdio_station_tb_top;
  localparam int HALF = 4;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        sw_mode = 1'b1;
  logic [7:0]  cfg_primary = 8'h05, cfg_secondary = 8'h09;
  logic        cmd_valid = 1'b0, cmd_write = 1'b0;
  logic [4:0]  cmd_phy = '0, cmd_reg = '0;
  logic [15:0] cmd_wdata = '0;
  logic        cmd_ready, rsp_valid, busy, mdc, mdio_o, mdio_oe;
  logic [15:0] rsp_rdata;
  logic        mdio_i = 1'b1;

  always #2.5 clk = ~clk;

  mdio_station #(.HALF_CYCLES(HALF)) dut_i (
    .clk(clk), .rst_n(rst_n), .sw_mode(sw_mode),
    .cfg_primary(cfg_primary), .cfg_secondary(cfg_secondary),
    .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_write(cmd_write),
    .cmd_phy(cmd_phy), .cmd_reg(cmd_reg), .cmd_wdata(cmd_wdata),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .busy(busy),
    .mdc(mdc), .mdio_o(mdio_o), .mdio_oe(mdio_oe), .mdio_i(mdio_i)
  );

  int tests = 0, fails = 0;

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // PHY model and frame log
  logic [15:0] phy_regs [32][32];
  logic [1:0]  flog_op  [64];
  logic [4:0]  flog_phy [64];
  logic [4:0]  flog_reg [64];
  logic [15:0] flog_dat [64];
  int flog_n = 0;
  int ph = 0, cnt = 0, ones = 0;
  logic [13:0] hdr;
  logic [15:0] dat, rdv;
  logic [1:0]  cur_op;
  logic prev_mdc = 1'b0, prev_oe = 1'b0, prev_o = 1'b1;
  int lvl_len = 0, lvl_seen = 0, mdc_bad = 0, edge_bad = 0;

  always @(negedge clk) begin
    if (!rst_n) begin
      ph = 0; ones = 0; mdio_i = 1'b1; lvl_len = 0; lvl_seen = 0;
      prev_mdc = mdc; prev_oe = mdio_oe; prev_o = mdio_o;
    end else begin
      if ((mdio_oe !== prev_oe || mdio_o !== prev_o) && !(prev_mdc && !mdc)) edge_bad++;
      lvl_len++;
      if (mdc !== prev_mdc) begin
        if (lvl_seen > 0 && lvl_len != HALF) mdc_bad++;
        lvl_seen++;
        lvl_len = 0;
      end
      if (mdc && !prev_mdc) begin
        case (ph)
          0: begin
            if (mdio_oe && mdio_o) ones++;
            else if (mdio_oe && !mdio_o && ones > 0) begin
              chk(ones == 32, "R3 preamble length", ones, 32);
              ph = 1; cnt = 1; hdr = '0;
            end else ones = 0;
          end
          1: begin
            chk(mdio_oe, "R3 header driven", mdio_oe, 1);
            hdr = {hdr[12:0], mdio_o}; cnt++;
            if (cnt == 14) begin
              chk(hdr[12] == 1'b1, "R3 start bits", hdr[13:12], 2'b01);
              cur_op = hdr[11:10];
              ph = 2; cnt = 0;
              if (cur_op == 2'b10) begin
                rdv = phy_regs[hdr[9:5]][hdr[4:0]];
                mdio_i = 1'b1;
              end
            end
          end
          2: begin
            cnt++;
            if (cur_op == 2'b10) begin
              chk(!mdio_oe, "R4 turnaround released", mdio_oe, 0);
              mdio_i = (cnt == 1) ? 1'b0 : rdv[15];
            end else begin
              chk(mdio_oe && mdio_o == (cnt == 1), "R3 write turnaround", {mdio_oe, mdio_o}, {1'b1, cnt == 1});
            end
            if (cnt == 2) begin ph = 3; cnt = 0; dat = '0; end
          end
          default: begin
            if (cur_op == 2'b10) begin
              if (mdio_oe) chk(1'b0, "R4 data released", mdio_oe, 0);
              cnt++;
              mdio_i = (cnt < 16) ? rdv[15-cnt] : 1'b1;
            end else begin
              dat = {dat[14:0], mdio_o}; cnt++;
            end
            if (cnt == 16) begin
              if (cur_op == 2'b01) phy_regs[hdr[9:5]][hdr[4:0]] = dat;
              if (flog_n < 64) begin
                flog_op[flog_n] = cur_op; flog_phy[flog_n] = hdr[9:5];
                flog_reg[flog_n] = hdr[4:0];
                flog_dat[flog_n] = (cur_op == 2'b10) ? rdv : dat;
                flog_n++;
              end
              ph = 0; ones = 0;
            end
          end
        endcase
      end
      prev_mdc = mdc; prev_oe = mdio_oe; prev_o = mdio_o;
    end
  end

  task automatic do_reset(input logic [7:0] p, input logic [7:0] s);
    int nseq, en;
    logic [4:0] ephy [3];
    cfg_primary = p; cfg_secondary = s;
    @(negedge clk); rst_n = 1'b0;
    repeat (4) @(negedge clk);
    flog_n = 0;
    chk(mdio_oe == 0 && mdc == 0 && busy == 1, "R1 reset state", {mdio_oe, mdc, busy}, 3'b001);
    rst_n = 1'b1;
    @(negedge clk);
    chk(busy && !cmd_ready, "R7 busy after reset", {busy, cmd_ready}, 2'b10);
    nseq = 0;
    for (int i = 0; i < 5000 && busy; i++) begin
      @(negedge clk);
      if (busy && cmd_ready) nseq++;
      if (rsp_valid) nseq += 100;
    end
    chk(nseq == 0 && !busy, "R7 hold-off during sequence", nseq, 0);
    ephy[0] = 5'd0; en = 1;
    if (p[7:5] != 3'b111) begin ephy[en] = p[4:0]; en++; end
    if (s[7:5] != 3'b111) begin ephy[en] = s[4:0]; en++; end
    chk(flog_n == en, "R6 sequence frame count", flog_n, en);
    for (int i = 0; i < en && i < flog_n; i++) begin
      chk(flog_op[i] == 2'b01 && flog_reg[i] == 0 && flog_dat[i] == 16'h0C00,
          "R5 isolate write", {flog_op[i], flog_reg[i], flog_dat[i]}, {2'b01, 5'd0, 16'h0C00});
      chk(flog_phy[i] == ephy[i], "R5 sequence order", flog_phy[i], ephy[i]);
    end
  endtask

  task automatic do_cmd(input logic wr, input logic [4:0] ph_a, input logic [4:0] rg,
                        input logic [15:0] wd, output logic [15:0] rd);
    int n0, rdy_bad;
    n0 = flog_n; rdy_bad = 0;
    @(negedge clk);
    cmd_valid = 1'b1; cmd_write = wr; cmd_phy = ph_a; cmd_reg = rg; cmd_wdata = wd;
    for (int i = 0; i < 3000 && !cmd_ready; i++) @(negedge clk);
    @(negedge clk);
    cmd_valid = 1'b0;
    for (int i = 0; i < 3000 && !rsp_valid; i++) begin
      if (cmd_ready) rdy_bad++;
      @(negedge clk);
    end
    chk(rsp_valid && rdy_bad == 0, "R8 response and ready held low", {rsp_valid, rdy_bad[7:0]}, 9'h100);
    rd = rsp_rdata;
    @(negedge clk);
    chk(!rsp_valid, "R8 single-cycle response", rsp_valid, 0);
    repeat (2 * HALF + 2) @(negedge clk);
    chk(mdio_oe == 0, "R10 released when idle", mdio_oe, 0);
    chk(flog_n == n0 + 1, "R8 one frame per command", flog_n, n0 + 1);
    if (flog_n == n0 + 1)
      chk(flog_op[n0] == (wr ? 2'b01 : 2'b10) && flog_phy[n0] == ph_a && flog_reg[n0] == rg,
          "R3 opcode and addresses", {flog_op[n0], flog_phy[n0], flog_reg[n0]}, {(wr ? 2'b01 : 2'b10), ph_a, rg});
  endtask

  initial begin
    logic [15:0] rd, expv;
    int n0, rdy_seen;
    void'($urandom(32'd4242));
    for (int i = 0; i < 32; i++)
      for (int j = 0; j < 32; j++) phy_regs[i][j] = 16'($urandom);

    do_reset(8'h05, 8'h09);
    do_reset(8'h0B, 8'hE4);
    do_reset(8'hE7, 8'h83);
    do_reset(8'hFF, 8'hE1);

    // directed corners
    do_cmd(1'b1, 5'd31, 5'd31, 16'hFFFF, rd);
    chk(phy_regs[31][31] == 16'hFFFF, "R3 write data all ones", phy_regs[31][31], 16'hFFFF);
    do_cmd(1'b1, 5'd0, 5'd1, 16'h0000, rd);
    chk(phy_regs[0][1] == 16'h0000, "R3 write data all zeros", phy_regs[0][1], 0);
    phy_regs[3][2] = 16'h8001;
    do_cmd(1'b0, 5'd3, 5'd2, 16'h0, rd);
    chk(rd == 16'h8001, "R4 read edge bits", rd, 16'h8001);
    do_cmd(1'b1, 5'd4, 5'd4, 16'h1234, rd);
    chk(rd == 16'h8001, "R4 read data held across write", rd, 16'h8001);

    // software ownership off
    sw_mode = 1'b0;
    n0 = flog_n; rdy_seen = 0;
    @(negedge clk);
    cmd_valid = 1'b1; cmd_write = 1'b0; cmd_phy = 5'd7; cmd_reg = 5'd9;
    for (int i = 0; i < 1000; i++) begin
      @(negedge clk);
      if (cmd_ready) rdy_seen++;
    end
    chk(rdy_seen == 0 && flog_n == n0, "R9 no command while hardware owns", {rdy_seen[7:0], flog_n[7:0]}, {8'd0, n0[7:0]});
    cmd_valid = 1'b0;
    sw_mode = 1'b1;
    expv = phy_regs[7][9];
    do_cmd(1'b0, 5'd7, 5'd9, 16'h0, rd);
    chk(rd == expv, "R9 command proceeds after mode returns", rd, expv);

    // constrained random traffic
    for (int k = 0; k < 30; k++) begin
      logic w;
      logic [4:0] pa, ra;
      logic [15:0] wd;
      w = 1'($urandom); pa = 5'($urandom); ra = 5'($urandom); wd = 16'($urandom);
      expv = phy_regs[pa][ra];
      do_cmd(w, pa, ra, wd, rd);
      if (w) chk(phy_regs[pa][ra] == wd, "R3 random write data", phy_regs[pa][ra], wd);
      else   chk(rd == expv, "R4 random read data", rd, expv);
    end

    chk(mdc_bad == 0, "R1 mdc half period", mdc_bad, 0);
    chk(edge_bad == 0, "R2 output changes only on falling mdc", edge_bad, 0);
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (180000) @(posedge clk);
    tests++; fails++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule